// File: doc/BRIEF.md
# Peripheral Clock-Stop and Reset Control Bank

This block is a small memory-mapped control bank that owns the gating and reset state of up to 64 peripherals. It keeps one 64-bit vector of peripheral reset lines and one 64-bit vector of clock-stop bits. Each vector is spread over two 32-bit words, and every word is reachable at two addresses. The base address sets bits and the neighbouring address clears them, so software can flip single lines without a read-modify-write sequence. A third word carries the divide-by-13 select for the first UART reference group. The select for the second UART group sits in the top bit of the low clock-stop word.

The bank is driven by a plain synchronous register port with address, write strobe, write data, read strobe and registered read data. Its outputs go straight to the chip's clock gates and reset tree. Reset lines are active high, meaning the peripheral is held in reset. Clock enables are active high. Clock line 14 is the one gate whose register bit has the opposite sense to all the others.

Top module: `clkrst_bank`

## Requirements
- R1: After synchronous reset every reset line is 1, every clock enable is 0, both divide-by-13 selects are 0, and a read of 0x080 returns 0x7FFF_BFFF.
- R2: Reset lines 0..31 are bits 0..31 of the word at 0x040, and lines 32..63 are bits 0..31 of the word at 0x050 (bit = line mod 32). A reset bit of 1 drives the line high.
- R3: A write to a word's base address (0x040, 0x050, 0x080, 0x090, 0x0C0) sets every bit that is 1 in the data and leaves the bits written as 0 unchanged.
- R4: A write to base+4 (0x044, 0x054, 0x084, 0x094, 0x0C4) clears every bit that is 1 in the data and leaves the other bits unchanged.
- R5: Clock bits 0..31 live at 0x080 and bits 32..63 at 0x090. For every line other than 14 and 31, the clock enable is 1 exactly when its stop bit is 0.
- R6: Clock line 14 has reversed polarity: its enable is 1 exactly when bit 14 of 0x080 is 1.
- R7: Bit 31 of 0x080 drives the second-group UART divide-by-13 select. Clock enable 31 is always 0.
- R8: Bit 12 of the word at 0x0C0 drives the first-group UART divide-by-13 select. All other bits of that word read as 0.
- R9: When the read strobe is high, read data takes the word state of the addressed base or clear alias at the next clock edge. Otherwise read data holds its value.
- R10: Reads of any other address, including addresses that are not multiples of 4, return 0. Writes to those addresses change nothing.
- R11: A read and a write to the same word in the same cycle return the value from before the write.
- R12: Without a write strobe, every output line keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 12 | Byte address of the access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data, used as a bit mask for set or clear |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| periph_rst | output | 64 | Per-peripheral reset lines, 1 = held in reset |
| periph_clk_en | output | 64 | Per-peripheral clock enables, 1 = running |
| uart_a_div13 | output | 1 | Divide-by-13 select, first UART reference group |
| uart_b_div13 | output | 1 | Divide-by-13 select, second UART reference group |

## Verification
The hardest case to reach is line 14. Its enable only rises after software writes a 1 to a bit that is 0 at reset, in the same word as the 31st bit. That 31st bit is not a gate at all, so a single wrong mask hides the error. The directed writes set and clear bit 14 and bit 31 on their own, on top of a non-trivial pattern already in that word. The bench then compares the whole enable vector, not single lines. A read and a write to the same word in the same cycle are forced together to show that the read port samples the state from before the write.

// File: rtl/clkrst_pkg.sv
package clkrst_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned IDX_W  = 4;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_RST  = 2'd1,
        TGT_CLK  = 2'd2,
        TGT_MISC = 2'd3
    } target_e;

    typedef enum logic {
        SIDE_SET = 1'b0,
        SIDE_CLR = 1'b1
    } side_e;

    typedef struct packed {
        target_e          tgt;
        side_e            side;
        logic [IDX_W-1:0] word;
    } access_t;

    // Reset image of one clock-stop word: all stopped, except the
    // reversed-polarity gate (0 = stopped) and the divider select (off).
    function automatic logic [WORD_W-1:0] stop_init(int unsigned word,
                                                    int unsigned inv_idx,
                                                    int unsigned sel_idx);
        logic [WORD_W-1:0] v;
        v = '1;
        for (int unsigned b = 0; b < WORD_W; b++) begin
            if ((word * WORD_W + b) == inv_idx || (word * WORD_W + b) == sel_idx)
                v[b] = 1'b0;
        end
        return v;
    endfunction

endpackage

// File: rtl/clkrst_decode.sv
module clkrst_decode
    import clkrst_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_WORDS = 2,
    parameter int unsigned RST_BASE  = 32'h040,
    parameter int unsigned CLK_BASE  = 32'h080,
    parameter int unsigned MISC_BASE = 32'h0C0,
    parameter int unsigned STRIDE    = 16,
    parameter int unsigned CLR_OFS   = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output access_t           acc
);

    always_comb begin
        acc.tgt  = TGT_NONE;
        acc.side = SIDE_SET;
        acc.word = '0;
        for (int unsigned w = 0; w < NUM_WORDS; w++) begin
            if (addr == ADDR_W'(RST_BASE + w * STRIDE)) begin
                acc.tgt = TGT_RST; acc.side = SIDE_SET; acc.word = IDX_W'(w);
            end
            if (addr == ADDR_W'(RST_BASE + w * STRIDE + CLR_OFS)) begin
                acc.tgt = TGT_RST; acc.side = SIDE_CLR; acc.word = IDX_W'(w);
            end
            if (addr == ADDR_W'(CLK_BASE + w * STRIDE)) begin
                acc.tgt = TGT_CLK; acc.side = SIDE_SET; acc.word = IDX_W'(w);
            end
            if (addr == ADDR_W'(CLK_BASE + w * STRIDE + CLR_OFS)) begin
                acc.tgt = TGT_CLK; acc.side = SIDE_CLR; acc.word = IDX_W'(w);
            end
        end
        if (addr == ADDR_W'(MISC_BASE)) begin
            acc.tgt = TGT_MISC; acc.side = SIDE_SET;
        end
        if (addr == ADDR_W'(MISC_BASE + CLR_OFS)) begin
            acc.tgt = TGT_MISC; acc.side = SIDE_CLR;
        end
    end

endmodule

// File: rtl/clkrst_bitword.sv
module clkrst_bitword
    import clkrst_pkg::*;
#(
    parameter logic [WORD_W-1:0] INIT_VAL  = '1,
    parameter logic [WORD_W-1:0] IMPL_MASK = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [WORD_W-1:0] mask,
    output logic [WORD_W-1:0] q
);

    logic [WORD_W-1:0] nxt;

    always_comb begin
        nxt = q;
        if (set_en) nxt = nxt | mask;
        if (clr_en) nxt = nxt & ~mask;
        nxt = nxt & IMPL_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= INIT_VAL & IMPL_MASK;
        else     q <= nxt;
    end

endmodule

// File: rtl/clkrst_outmap.sv
module clkrst_outmap #(
    parameter int unsigned NUM_LINES = 64,
    parameter int unsigned INV_IDX   = 14,
    parameter int unsigned SEL_IDX   = 31
) (
    input  logic [NUM_LINES-1:0] stop_vec,
    output logic [NUM_LINES-1:0] clk_en,
    output logic                 sel_out
);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        if (i == INV_IDX) begin : g_inv
            assign clk_en[i] = stop_vec[i];
        end else if (i == SEL_IDX) begin : g_sel
            assign clk_en[i] = 1'b0;
        end else begin : g_norm
            assign clk_en[i] = ~stop_vec[i];
        end
    end

    assign sel_out = stop_vec[SEL_IDX];

endmodule

// File: rtl/clkrst_bank.sv
module clkrst_bank
    import clkrst_pkg::*;
#(
    parameter int unsigned ADDR_W       = 12,
    parameter int unsigned NUM_LINES    = 64,
    parameter int unsigned RST_BASE     = 32'h040,
    parameter int unsigned CLK_BASE     = 32'h080,
    parameter int unsigned MISC_BASE    = 32'h0C0,
    parameter int unsigned INV_IDX      = 14,
    parameter int unsigned SEL_IDX      = 31,
    parameter int unsigned MISC_DIV_BIT = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [WORD_W-1:0]    reg_wdata,
    input  logic                 reg_rd,
    output logic [WORD_W-1:0]    reg_rdata,
    output logic [NUM_LINES-1:0] periph_rst,
    output logic [NUM_LINES-1:0] periph_clk_en,
    output logic                 uart_a_div13,
    output logic                 uart_b_div13
);

    localparam int unsigned NUM_WORDS = NUM_LINES / WORD_W;
    localparam logic [WORD_W-1:0] MISC_MASK = WORD_W'(1) << MISC_DIV_BIT;

    access_t acc;

    logic [WORD_W-1:0]    rst_word [NUM_WORDS];
    logic [WORD_W-1:0]    stop_word[NUM_WORDS];
    logic [WORD_W-1:0]    misc_word;
    logic [NUM_LINES-1:0] stop_vec;
    logic [WORD_W-1:0]    rd_word;

    clkrst_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_WORDS(NUM_WORDS),
        .RST_BASE (RST_BASE),
        .CLK_BASE (CLK_BASE),
        .MISC_BASE(MISC_BASE),
        .STRIDE   (16),
        .CLR_OFS  (4)
    ) u_dec (
        .addr(reg_addr),
        .acc (acc)
    );

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic hit_rst, hit_clk;
        assign hit_rst = reg_wr && (acc.tgt == TGT_RST) && (acc.word == IDX_W'(w));
        assign hit_clk = reg_wr && (acc.tgt == TGT_CLK) && (acc.word == IDX_W'(w));

        clkrst_bitword #(
            .INIT_VAL ('1),
            .IMPL_MASK('1)
        ) u_rst (
            .clk   (clk),
            .rst   (rst),
            .set_en(hit_rst && (acc.side == SIDE_SET)),
            .clr_en(hit_rst && (acc.side == SIDE_CLR)),
            .mask  (reg_wdata),
            .q     (rst_word[w])
        );

        clkrst_bitword #(
            .INIT_VAL (stop_init(w, INV_IDX, SEL_IDX)),
            .IMPL_MASK('1)
        ) u_stop (
            .clk   (clk),
            .rst   (rst),
            .set_en(hit_clk && (acc.side == SIDE_SET)),
            .clr_en(hit_clk && (acc.side == SIDE_CLR)),
            .mask  (reg_wdata),
            .q     (stop_word[w])
        );

        assign periph_rst[w*WORD_W +: WORD_W] = rst_word[w];
        assign stop_vec  [w*WORD_W +: WORD_W] = stop_word[w];
    end

    clkrst_bitword #(
        .INIT_VAL ('0),
        .IMPL_MASK(MISC_MASK)
    ) u_misc (
        .clk   (clk),
        .rst   (rst),
        .set_en(reg_wr && (acc.tgt == TGT_MISC) && (acc.side == SIDE_SET)),
        .clr_en(reg_wr && (acc.tgt == TGT_MISC) && (acc.side == SIDE_CLR)),
        .mask  (reg_wdata),
        .q     (misc_word)
    );

    clkrst_outmap #(
        .NUM_LINES(NUM_LINES),
        .INV_IDX  (INV_IDX),
        .SEL_IDX  (SEL_IDX)
    ) u_map (
        .stop_vec(stop_vec),
        .clk_en  (periph_clk_en),
        .sel_out (uart_b_div13)
    );

    assign uart_a_div13 = misc_word[MISC_DIV_BIT];

    always_comb begin
        rd_word = '0;
        for (int unsigned w = 0; w < NUM_WORDS; w++) begin
            if (acc.word == IDX_W'(w)) begin
                if (acc.tgt == TGT_RST) rd_word = rst_word[w];
                if (acc.tgt == TGT_CLK) rd_word = stop_word[w];
            end
        end
        if (acc.tgt == TGT_MISC) rd_word = misc_word;
    end

    always_ff @(posedge clk) begin
        if (rst)         reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_word;
    end

endmodule

// File: rtl/clkrst_bank_chk.sv
module clkrst_bank_chk
    import clkrst_pkg::*;
#(
    parameter int unsigned ADDR_W       = 12,
    parameter int unsigned NUM_LINES    = 64,
    parameter int unsigned RST_BASE     = 32'h040,
    parameter int unsigned CLK_BASE     = 32'h080,
    parameter int unsigned MISC_BASE    = 32'h0C0,
    parameter int unsigned MISC_DIV_BIT = 12
) (
    input logic                 clk,
    input logic                 rst,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic                 reg_wr,
    input logic [WORD_W-1:0]    reg_wdata,
    input logic                 reg_rd,
    input logic [WORD_W-1:0]    reg_rdata,
    input logic [NUM_LINES-1:0] periph_rst,
    input logic [NUM_LINES-1:0] periph_clk_en,
    input logic                 uart_a_div13,
    input logic                 uart_b_div13
);

    // R3: base-address write sets the masked reset lines of the low word
    a_r3_set_low_rst: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_W'(RST_BASE))
        |=> ((periph_rst[WORD_W-1:0] & $past(reg_wdata)) == $past(reg_wdata)));

    // R4, R5: clear alias of the high clock word starts the masked clocks
    a_r4_clear_high_clk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_W'(CLK_BASE + 16 + 4))
        |=> ((periph_clk_en[2*WORD_W-1:WORD_W] & $past(reg_wdata)) == $past(reg_wdata)));

    // R8: setting the misc divider bit raises the first UART group select
    a_r8_misc_div: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_W'(MISC_BASE) && reg_wdata[MISC_DIV_BIT])
        |=> uart_a_div13);

    // R9: read data holds without a read strobe
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> $stable(reg_rdata));

    // R10: a hole in the map reads as zero
    a_r10_hole_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == ADDR_W'(MISC_BASE + 8)) |=> (reg_rdata == '0));

    // R12: no write strobe, no output change
    a_r12_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !reg_wr |=> ($stable(periph_rst) && $stable(periph_clk_en)
                     && $stable(uart_a_div13) && $stable(uart_b_div13)));

endmodule

bind clkrst_bank clkrst_bank_chk #(
    .ADDR_W      (ADDR_W),
    .NUM_LINES   (NUM_LINES),
    .RST_BASE    (RST_BASE),
    .CLK_BASE    (CLK_BASE),
    .MISC_BASE   (MISC_BASE),
    .MISC_DIV_BIT(MISC_DIV_BIT)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_addr     (reg_addr),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rd       (reg_rd),
    .reg_rdata    (reg_rdata),
    .periph_rst   (periph_rst),
    .periph_clk_en(periph_clk_en),
    .uart_a_div13 (uart_a_div13),
    .uart_b_div13 (uart_b_div13)
);

// File: tb/clkrst_bank_test.sv
module clkrst_bank_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_rdata;
    logic [63:0] periph_rst;
    logic [63:0] periph_clk_en;
    logic        uart_a_div13;
    logic        uart_b_div13;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    clkrst_bank uut (
        .clk          (clk),
        .rst          (rst),
        .reg_addr     (reg_addr),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_rd       (reg_rd),
        .reg_rdata    (reg_rdata),
        .periph_rst   (periph_rst),
        .periph_clk_en(periph_clk_en),
        .uart_a_div13 (uart_a_div13),
        .uart_b_div13 (uart_b_div13)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 reset lines", periph_rst, {64{1'b1}});
        check("R1 clock enables", periph_clk_en, 64'h0);
        check("R1 uart selects", {62'h0, uart_a_div13, uart_b_div13}, 64'h0);
        rd(12'h080, d);
        check("R1 read 0x080", {32'h0, d}, 64'h7FFF_BFFF);
        rd(12'h050, d);
        check("R2 read 0x050", {32'h0, d}, 64'hFFFF_FFFF);
    endtask

    task automatic t_rst_clear_set();
        logic [31:0] d;
        wr(12'h044, 32'h0000_0005);
        check("R4 clear low reset", periph_rst, 64'hFFFF_FFFF_FFFF_FFFA);
        rd(12'h044, d);
        check("R9 read clear alias", {32'h0, d}, 64'hFFFF_FFFA);
        wr(12'h054, 32'h8000_0001);
        check("R2 clear high reset", periph_rst, 64'h7FFF_FFFE_FFFF_FFFA);
        wr(12'h040, 32'h0000_0001);
        check("R3 set low reset", periph_rst, 64'h7FFF_FFFE_FFFF_FFFB);
    endtask

    task automatic t_clock();
        wr(12'h084, 32'h0000_0003);
        check("R5 start clocks 0,1", periph_clk_en, 64'h0000_0000_0000_0003);
        wr(12'h080, 32'h0000_0001);
        check("R3 stop clock 0", periph_clk_en, 64'h0000_0000_0000_0002);
        wr(12'h094, 32'h0000_00F0);
        check("R5 high clock word", periph_clk_en, 64'h0000_00F0_0000_0002);
    endtask

    task automatic t_inv14();
        wr(12'h080, 32'h0000_4000);
        check("R6 line 14 enabled by 1", periph_clk_en, 64'h0000_00F0_0000_4002);
        wr(12'h084, 32'h0000_4000);
        check("R6 line 14 off by 0", periph_clk_en, 64'h0000_00F0_0000_0002);
    endtask

    task automatic t_uartb();
        logic [31:0] d;
        wr(12'h080, 32'h8000_0000);
        check("R7 second group select", {63'h0, uart_b_div13}, 64'h1);
        check("R7 enable 31 low", periph_clk_en, 64'h0000_00F0_0000_0002);
        rd(12'h084, d);
        check("R7 read stop word", {32'h0, d}, 64'hFFFF_BFFD);
        wr(12'h084, 32'h8000_0000);
        check("R7 select cleared", {63'h0, uart_b_div13}, 64'h0);
    endtask

    task automatic t_misc();
        logic [31:0] d;
        wr(12'h0C0, 32'hFFFF_FFFF);
        check("R8 first group select", {63'h0, uart_a_div13}, 64'h1);
        rd(12'h0C4, d);
        check("R8 misc readback", {32'h0, d}, 64'h0000_1000);
        wr(12'h0C4, 32'h0000_1000);
        check("R8 select cleared", {63'h0, uart_a_div13}, 64'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(12'h046, 32'hFFFF_FFFF);
        check("R10 misaligned write ignored", periph_rst, 64'h7FFF_FFFE_FFFF_FFFB);
        wr(12'h098, 32'hFFFF_FFFF);
        check("R10 hole write ignored", periph_clk_en, 64'h0000_00F0_0000_0002);
        rd(12'h0FC, d);
        check("R10 hole reads zero", {32'h0, d}, 64'h0);
        rd(12'h046, d);
        check("R10 misaligned reads zero", {32'h0, d}, 64'h0);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        reg_addr = 12'h044; reg_wdata = 32'h0000_0008; reg_wr = 1'b1; reg_rd = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0;
        check("R11 read sees old value", {32'h0, reg_rdata}, 64'hFFFF_FFFB);
        check("R11 write applied", periph_rst, 64'h7FFF_FFFE_FFFF_FFF3);
    endtask

    task automatic t_idle();
        @(negedge clk);
        reg_addr = 12'h040; reg_wdata = 32'hFFFF_FFFF;
        repeat (5) @(negedge clk);
        check("R12 reset lines held", periph_rst, 64'h7FFF_FFFE_FFFF_FFF3);
        check("R12 enables held", periph_clk_en, 64'h0000_00F0_0000_0002);
        check("R9 read data held", {32'h0, reg_rdata}, 64'hFFFF_FFFB);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_rst_clear_set();
        t_clock();
        t_inv14();
        t_uartb();
        t_misc();
        t_unmapped();
        t_same_cycle();
        t_idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule